// File: doc/BRIEF.md
# Two-Wire Register-Pointer Target

This block is a target on a two-wire serial bus (I2C/SMBus style) that gives a bus master byte access to a small register file held inside the block. It watches the SCL and SDA lines through synchronizers running on the system clock. It recognises bus start, repeated start and stop conditions, and it answers only to one fixed 7-bit device address. It drives the bus only through an open-drain enable: when `sda_oe` is 1, SDA is pulled low; when it is 0, SDA is released.

A master writes by addressing the target with the direction bit clear. The first byte after the address is a command byte, and its low bits load an internal register pointer. Each later byte is stored at the pointer, and the pointer then moves on to the next register. To read, the master writes the pointer in the same way, issues a repeated start and addresses the target again with the direction bit set. The target then shifts out the register at the pointer. It moves to the next register each time the master acknowledges a byte.

A local port lets surrounding logic read any register without waiting and write registers directly. This is how the chip preloads values that the master will read.

Top module: `i2c_regptr_target`

## Requirements
- R1: After reset `sda_oe` is 0, every register reads 0 on the local port, and the register pointer is 0, so a read with no command byte first returns register 0.
- R2: A START is SDA falling while SCL is high. A repeated START is treated the same way. A STOP is SDA rising while SCL is high. A START or STOP in the middle of a byte drops that byte without writing anything, and the next byte is taken as an address byte.
- R3: The address byte carries the 7-bit address 1100100 in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). On a match, the target acknowledges by pulling SDA low (`sda_oe` = 1) during the ninth clock. On any other address, the target keeps SDA released and writes nothing until the next START or STOP.
- R4: In a write, the target acknowledges the first byte after the address and loads its low 3 bits into the register pointer.
- R5: In a write, each later byte is acknowledged and stored at the pointer, and the pointer then advances by one. The pointer wraps from register 7 to register 0.
- R6: After an address match with bit 0 = 1, the target sends the register at the pointer MSB first, with a 0 bit shown as `sda_oe` = 1.
- R7: If the master acknowledges a read byte, the pointer advances by one (wrapping from 7 to 0) and the next register is sent. On a master NAK the pointer is left as it is, and SDA stays released until the next START.
- R8: `sda_oe` changes only in the clock cycle that follows a detected SCL falling edge, so SDA never changes while SCL is high.
- R9: The pointer keeps its value across a STOP, across an aborted byte and across a non-matching transaction.
- R10: `loc_rdata` shows the register selected by `loc_addr` in the same cycle. A cycle with `loc_we` = 1 stores `loc_wdata` at `loc_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| loc_we | input | 1 | Local register write strobe |
| loc_addr | input | 3 | Local register index |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Register at `loc_addr` |

## Verification
The hardest states to reach from the ports are the aborted byte and the pointer that must survive it. The bench sends a START, the address and a command byte. It then clocks only part of the next byte and issues a STOP or a repeated START. After that it checks that the target register kept its old value and that a following read, with or without a command byte, starts at the pointer value from before the abort. Wrap-around is reached by setting the pointer to 6 or 7 and then continuing a write or read burst across the last register.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RX   = 2'd1,
    PH_TX   = 2'd2,
    PH_SKIP = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    K_ADDR = 2'd0,
    K_CMD  = 2'd1,
    K_DATA = 2'd2
  } kind_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/i2c_rp_linesync.sv
module i2c_rp_linesync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_pipe_q, scl_pipe_d;
  logic [STAGES-1:0] sda_pipe_q, sda_pipe_d;
  logic              scl_prev_q, sda_prev_q;
  logic              scl_s;

  always_comb begin
    scl_pipe_d = {scl_pipe_q[STAGES-2:0], scl_i};
    sda_pipe_d = {sda_pipe_q[STAGES-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign scl_s     = scl_pipe_q[STAGES-1];
  assign sda_s     = sda_pipe_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s & scl_prev_q;
  assign bus_start = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign bus_stop  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/i2c_rp_regfile.sv
module i2c_rp_regfile #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          loc_we,
  input  logic [AW-1:0] loc_addr,
  input  logic [DW-1:0] loc_wdata,
  output logic [DW-1:0] loc_rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mem_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
    if (bus_we)      mem_d[bus_addr] = bus_wdata;
    else if (loc_we) mem_d[loc_addr] = loc_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign bus_rdata = mem_q[bus_addr];
  assign loc_rdata = mem_q[loc_addr];

  // R5
  bus_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> mem_q[$past(bus_addr)] == $past(bus_wdata));

  // R10
  loc_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_we && !bus_we) |=> mem_q[$past(loc_addr)] == $past(loc_wdata));
endmodule

// File: rtl/i2c_rp_engine.sv
module i2c_rp_engine
  import i2c_rp_pkg::*;
#(
  parameter int unsigned AW       = 3,
  parameter logic [6:0]  DEV_ADDR = 7'b1100100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [AW-1:0]     ptr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W - 1);
  localparam logic [3:0] ACK_SLOT = 4'(BYTE_W);

  phase_e            phase_q, phase_d;
  kind_e             kind_q, kind_d;
  logic [3:0]        cnt_q, cnt_d;
  logic              ack_q, ack_d;
  logic              rw_q, rw_d;
  logic              mack_q, mack_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [AW-1:0]     ptr_q, ptr_d;
  logic              oe_q, oe_d;
  logic [BYTE_W-1:0] rx_byte;

  assign rx_byte = {sh_q[BYTE_W-2:0], sda_s};

  always_comb begin
    phase_d = phase_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    ack_d   = ack_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    oe_d    = oe_q;
    wr_en   = 1'b0;
    if (bus_start) begin
      phase_d = PH_RX;
      kind_d  = K_ADDR;
      cnt_d   = '0;
      ack_d   = 1'b0;
    end else if (bus_stop) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
      ack_d   = 1'b0;
    end else begin
      unique case (phase_q)
        PH_RX: begin
          if (scl_rise && !ack_q) begin
            sh_d  = rx_byte;
            cnt_d = cnt_q + 4'd1;
            if (cnt_q == LAST_BIT) begin
              unique case (kind_q)
                K_ADDR: begin
                  if (rx_byte[BYTE_W-1:1] == DEV_ADDR) rw_d = rx_byte[0];
                  else phase_d = PH_SKIP;
                end
                K_CMD:   ptr_d = rx_byte[AW-1:0];
                default: begin
                  wr_en = 1'b1;
                  ptr_d = ptr_q + 1'b1;
                end
              endcase
            end
          end else if (scl_fall) begin
            if (ack_q) begin
              ack_d = 1'b0;
              cnt_d = '0;
              oe_d  = 1'b0;
              if (kind_q == K_ADDR && rw_q) begin
                phase_d = PH_TX;
                sh_d    = rd_data;
                oe_d    = ~rd_data[BYTE_W-1];
              end else begin
                kind_d = (kind_q == K_ADDR) ? K_CMD : K_DATA;
              end
            end else if (cnt_q == ACK_SLOT) begin
              ack_d = 1'b1;
              oe_d  = 1'b1;
            end
          end
        end
        PH_TX: begin
          if (scl_rise) begin
            if (ack_q) begin
              mack_d = ~sda_s;
              if (!sda_s) ptr_d = ptr_q + 1'b1;
            end else begin
              cnt_d = cnt_q + 4'd1;
            end
          end else if (scl_fall) begin
            if (ack_q) begin
              ack_d = 1'b0;
              cnt_d = '0;
              if (mack_q) begin
                sh_d = rd_data;
                oe_d = ~rd_data[BYTE_W-1];
              end else begin
                phase_d = PH_SKIP;
                oe_d    = 1'b0;
              end
            end else if (cnt_q == ACK_SLOT) begin
              ack_d = 1'b1;
              oe_d  = 1'b0;
            end else begin
              oe_d = ~sh_q[BYTE_W-2];
              sh_d = sh_q << 1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      kind_q  <= K_ADDR;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      sh_q    <= '0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
      ack_q   <= ack_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      oe_q    <= oe_d;
    end
  end

  assign ptr     = ptr_q;
  assign wr_data = rx_byte;
  assign sda_oe  = oe_q;

  // R8
  oe_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> $past(scl_fall));

  // R3
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_SKIP |-> !oe_q);

  // R2
  start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (phase_q == PH_RX && kind_q == K_ADDR && cnt_q == 4'd0 && !ack_q));

  // R5
  wr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr_q == AW'($past(ptr_q) + 1'b1));

  // R9
  stop_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> ptr_q == $past(ptr_q));

  // R7
  mack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_TX && ack_q) |-> !oe_q);
endmodule

// File: rtl/i2c_regptr_target.sv
module i2c_regptr_target #(
  parameter logic [6:0]  DEV_ADDR    = 7'b1100100,
  parameter int unsigned REG_AW      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              loc_we,
  input  logic [REG_AW-1:0] loc_addr,
  input  logic [7:0]        loc_wdata,
  output logic [7:0]        loc_rdata
);
  localparam int unsigned DW = i2c_rp_pkg::BYTE_W;

  logic          rst_meta_q, rst_sync_q;
  logic          sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic [REG_AW-1:0] ptr;
  logic          wr_en;
  logic [DW-1:0] wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  i2c_rp_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  i2c_rp_engine #(.AW(REG_AW), .DEV_ADDR(DEV_ADDR)) u_engine (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .rd_data   (rd_data),
    .ptr       (ptr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe)
  );

  i2c_rp_regfile #(.AW(REG_AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .bus_we    (wr_en),
    .bus_addr  (ptr),
    .bus_wdata (wr_data),
    .bus_rdata (rd_data),
    .loc_we    (loc_we),
    .loc_addr  (loc_addr),
    .loc_wdata (loc_wdata),
    .loc_rdata (loc_rdata)
  );
endmodule

// File: tb/i2c_regptr_target_tb.sv
module i2c_regptr_target_tb;
  localparam int Q = 10;
  localparam logic [7:0] A_W = 8'hC8;
  localparam logic [7:0] A_R = 8'hC9;
  localparam logic [10:0] VEC [0:7] = '{
    {3'd2, 8'hC3}, {3'd5, 8'h1E}, {3'd0, 8'hFF}, {3'd7, 8'h80},
    {3'd3, 8'h6D}, {3'd1, 8'h01}, {3'd4, 8'hA5}, {3'd6, 8'h7E}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m;
  logic sda_bus;
  logic sda_oe;
  logic loc_we;
  logic [2:0] loc_addr;
  logic [7:0] loc_wdata, loc_rdata;

  int n_chk = 0;
  int n_err = 0;
  int oe_hi_chg = 0;
  logic oe_prev = 1'b0;
  logic quiet_watch = 1'b0;
  logic quiet_hit = 1'b0;
  logic done = 1'b0;
  logic [7:0] mdl [8];

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_regptr_target u_dut (
    .clk (clk), .rst_n (rst_n), .scl_i (scl_m), .sda_i (sda_bus),
    .sda_oe (sda_oe), .loc_we (loc_we), .loc_addr (loc_addr),
    .loc_wdata (loc_wdata), .loc_rdata (loc_rdata)
  );

  always @(negedge clk) begin
    if (scl_m && (sda_oe !== oe_prev)) oe_hi_chg++;
    oe_prev <= sda_oe;
    if (quiet_watch && sda_oe) quiet_hit <= 1'b1;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    send_bits(b, 8);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); acked = ~sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); d[i] = sda_bus; wq(); scl_m = 1'b0; wq();
    end
    sda_m = ~mack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic i2c_write(input logic [2:0] p, input int n, input logic [23:0] d,
                           output logic ok);
    logic a;
    ok = 1'b1;
    i2c_start();
    send_byte(A_W, a); ok &= a;
    send_byte({5'd0, p}, a); ok &= a;
    for (int i = 0; i < n; i++) begin
      send_byte(d[23 - 8*i -: 8], a); ok &= a;
    end
    i2c_stop();
  endtask

  task automatic i2c_read(input logic set_ptr, input logic [2:0] p, input int n,
                          output logic [23:0] r);
    logic a;
    logic [7:0] b;
    r = '0;
    i2c_start();
    if (set_ptr) begin
      send_byte(A_W, a);
      send_byte({5'd0, p}, a);
      i2c_start();
    end
    send_byte(A_R, a);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      r[23 - 8*i -: 8] = b;
    end
    i2c_stop();
  endtask

  task automatic loc_peek(input logic [2:0] a, output logic [7:0] v);
    loc_addr = a; @(negedge clk); v = loc_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic ok, a;
    logic [7:0] v;
    logic [23:0] r;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    loc_we = 1'b0; loc_addr = '0; loc_wdata = '0;
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 sda_oe after reset", {7'd0, sda_oe}, 8'h00);
    for (int i = 0; i < 8; i++) begin
      loc_peek(3'(i), v); chk("R1 register zero after reset", v, 8'h00);
    end

    // R10 local write and read
    loc_addr = 3'd0; loc_wdata = 8'h5A; loc_we = 1'b1;
    @(negedge clk); loc_we = 1'b0; mdl[0] = 8'h5A;
    loc_peek(3'd0, v); chk("R10 local write", v, 8'h5A);

    // R1 pointer is 0: read without command byte
    i2c_read(1'b0, 3'd0, 1, r);
    chk("R1 pointer reset read", r[23:16], 8'h5A);

    // table of single-byte writes and read-backs
    for (int k = 0; k < 8; k++) begin
      logic [2:0] p;
      logic [7:0] val;
      {p, val} = VEC[k];
      i2c_write(p, 1, {val, 16'h0}, ok);
      mdl[p] = val;
      chk("R4 write acknowledged", {7'd0, ok}, 8'h01);
      loc_peek(p, v); chk("R5 byte stored at pointer", v, val);
      i2c_read(1'b1, p, 1, r);
      chk("R6 read at pointer", r[23:16], val);
    end

    // R5 burst write with wrap 6,7,0
    i2c_write(3'd6, 3, 24'h112233, ok);
    mdl[6] = 8'h11; mdl[7] = 8'h22; mdl[0] = 8'h33;
    chk("R5 burst acks", {7'd0, ok}, 8'h01);
    loc_peek(3'd6, v); chk("R5 burst reg6", v, 8'h11);
    loc_peek(3'd7, v); chk("R5 burst reg7", v, 8'h22);
    loc_peek(3'd0, v); chk("R5 burst wrap reg0", v, 8'h33);

    // R7 burst read across wrap, NAK on last
    i2c_read(1'b1, 3'd7, 3, r);
    chk("R7 read first reg7", r[23:16], 8'h22);
    chk("R7 read wrap reg0", r[15:8], 8'h33);
    chk("R7 read reg1", r[7:0], mdl[1]);
    chk("R7 released after NAK", {7'd0, sda_oe}, 8'h00);
    // R9 pointer kept across stop: 7 -> 0 -> 1, NAK does not advance
    i2c_read(1'b0, 3'd0, 1, r);
    chk("R9 pointer after read burst", r[23:16], mdl[1]);

    // R3 mismatched address
    quiet_watch = 1'b1;
    i2c_start();
    send_byte(8'hCA, a);
    chk("R3 wrong address not acked", {7'd0, a}, 8'h00);
    send_byte(8'h02, a);
    send_byte(8'hEE, a);
    i2c_stop();
    i2c_start();
    send_byte(8'h49, a);
    chk("R3 wrong read address not acked", {7'd0, a}, 8'h00);
    send_bits(8'hFF, 8); send_bits(8'hFF, 1);
    i2c_stop();
    quiet_watch = 1'b0;
    chk("R3 target never drove SDA", {7'd0, quiet_hit}, 8'h00);
    loc_peek(3'd2, v); chk("R3 no write on mismatch", v, mdl[2]);
    i2c_read(1'b0, 3'd0, 1, r);
    chk("R9 pointer kept after mismatch", r[23:16], mdl[1]);

    // R2 STOP in the middle of a data byte
    i2c_start();
    send_byte(A_W, a);
    send_byte(8'h03, a);
    send_bits(8'h0F, 4);
    i2c_stop();
    loc_peek(3'd3, v); chk("R2 aborted byte not stored", v, mdl[3]);
    chk("R2 released after abort", {7'd0, sda_oe}, 8'h00);
    i2c_read(1'b0, 3'd0, 1, r);
    chk("R9 pointer kept after abort", r[23:16], mdl[3]);

    // R2 repeated START in the middle of a data byte
    i2c_start();
    send_byte(A_W, a);
    send_byte(8'h05, a);
    send_bits(8'h00, 3);
    i2c_start();
    send_byte(A_R, a);
    chk("R2 address acked after repeated start", {7'd0, a}, 8'h01);
    recv_byte(1'b0, v);
    i2c_stop();
    chk("R2 read after repeated-start abort", v, mdl[5]);
    loc_peek(3'd5, v); chk("R2 repeated-start abort no write", v, mdl[5]);

    // R8 SDA never changed while SCL high
    chk("R8 oe changes while SCL high", 8'(oe_hi_chg), 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule